// File: doc/BRIEF.md
# Shared Work-RAM Slot Ownership Mapper

The mapper decides which physical 32 KB chunk of a shared work RAM serves an access. Two banks of control bytes hold the mapping: bank 0 serves DSP code mappings and bank 1 serves DSP data mappings. Each bank has eight slots. Each control byte names the bus master that owns its chunk, and the 32 KB-granular position at which the chunk appears inside that master's window. A slot only takes part in a lookup while its enable bit is set.

An access presents a requester ID, a bank select and a window position. The block searches every enabled slot of the selected bank for one whose owner and position both match. It returns a hit and the physical slot index, or a miss. When several slots claim the same owner and position, the lowest-numbered slot is used. Read data from the RAM passes through on a hit and is forced to zero on a miss.

The lookup is combinational from the registered configuration, so a configuration write is visible to lookups from the following cycle. The RAM array and bus protocol timing are outside the block.

Top module: `swram_slot_mapper`

## Requirements
- R1: After synchronous reset every control byte of both banks reads 0x00, and every valid lookup misses.
- R2: A write stores bits 7 and 4:0 of the data. Bits 6:5 always read back as zero. `cfg_addr[3]` selects the bank (0 code, 1 data) and `cfg_addr[2:0]` selects the slot.
- R3: A configuration write changes `cfg_rdata` and lookup results from the cycle after the clock edge that takes the write; before that edge the old value is used.
- R4: Owner field bits 1:0 hold 0 for the first CPU and 1 for the second CPU; both 2 and 3 mean the DSP. A requester ID of 2 or 3 matches any DSP-owned slot.
- R5: A slot matches only if its position field, bits 4:2, equals `lk_pos`.
- R6: A slot whose bit 7 is 0 never produces a hit, whatever its other fields hold.
- R7: `lk_bank` (0 code, 1 data) restricts the search to that bank; slots of the other bank never hit.
- R8: When several enabled slots match, `lk_slot` reports the lowest-numbered one.
- R9: A valid lookup with no match raises `lk_miss` and drives `lk_rdata` to zero. On a hit, `lk_rdata` equals `lk_rdata_in`.
- R10: While `lk_valid` is low, `lk_hit` and `lk_miss` are both low.
- R11: `lk_hit` and `lk_miss` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_addr | input | 4 | Bit 3 selects the bank, bits 2:0 select the slot |
| cfg_wdata | input | 8 | Control byte to write |
| cfg_rdata | output | 8 | Control byte at `cfg_addr` |
| lk_valid | input | 1 | An access is presented this cycle |
| lk_bank | input | 1 | 0 code bank, 1 data bank |
| lk_req | input | 2 | Requester ID (0 CPU0, 1 CPU1, 2/3 DSP) |
| lk_pos | input | 3 | Window position in 32 KB units |
| lk_rdata_in | input | 32 | Read data from the shared RAM |
| lk_hit | output | 1 | An enabled slot matched |
| lk_miss | output | 1 | Valid access with no matching slot |
| lk_slot | output | 3 | Physical slot index of the hit (0 when none) |
| lk_rdata | output | 32 | Gated read data |

## Verification
The assertions assume that `rst` is held for at least one clock edge before any check matters, and that `cfg_addr` and `cfg_wdata` stay stable around the edge that takes a write; the readback check compares against the value sampled on that edge. The bench changes every input on the falling edge and holds it through the next rising edge, so each input is stable when it is sampled. Lookup inputs can change freely, because the lookup has no state and every property about it holds within a single cycle.

// File: rtl/swram_pkg.sv
package swram_pkg;

  localparam int REG_W    = 8;
  localparam int OWN_LO   = 0;
  localparam int OWN_HI   = 1;
  localparam int POS_LO   = 2;
  localparam int POS_HI   = 4;
  localparam int EN_BIT   = 7;
  localparam int POS_W    = POS_HI - POS_LO + 1;
  localparam logic [REG_W-1:0] KEEP_MASK = 8'h9F;

  typedef enum logic [1:0] {
    OWN_CPU0 = 2'd0,
    OWN_CPU1 = 2'd1,
    OWN_DSP  = 2'd2
  } owner_e;

  // Both upper owner codes collapse onto the DSP.
  function automatic owner_e owner_of(input logic [1:0] code);
    if (code[1])
      return OWN_DSP;
    else if (code[0])
      return OWN_CPU1;
    else
      return OWN_CPU0;
  endfunction

endpackage

// File: rtl/swram_cfg_bank.sv
module swram_cfg_bank
  import swram_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              we,
  input  logic [SLOT_W-1:0]                 waddr,
  input  logic [REG_W-1:0]                  wdata,
  output logic [NUM_SLOTS-1:0][REG_W-1:0]   slots
);

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)
        slots[i] <= '0;
      else if (we && (waddr == SLOT_W'(i)))
        slots[i] <= wdata & KEEP_MASK;
    end
  end

endmodule

// File: rtl/swram_slot_search.sv
module swram_slot_search
  import swram_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic [NUM_SLOTS-1:0][REG_W-1:0] slots,
  input  owner_e                          req_owner,
  input  logic [POS_W-1:0]                req_pos,
  output logic                            found,
  output logic [SLOT_W-1:0]               idx
);

  logic [NUM_SLOTS-1:0] match_vec;

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_cmp
    assign match_vec[i] = slots[i][EN_BIT]
                       && (owner_of(slots[i][OWN_HI:OWN_LO]) == req_owner)
                       && (slots[i][POS_HI:POS_LO] == req_pos);
  end

  // Scan from the top so the lowest matching slot is left standing.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (match_vec[i]) begin
        found = 1'b1;
        idx   = SLOT_W'(i);
      end
    end
  end

endmodule

// File: rtl/swram_slot_mapper.sv
module swram_slot_mapper
  import swram_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int DATA_W    = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         cfg_we,
  input  logic [$clog2(NUM_SLOTS):0]   cfg_addr,
  input  logic [7:0]                   cfg_wdata,
  output logic [7:0]                   cfg_rdata,
  input  logic                         lk_valid,
  input  logic                         lk_bank,
  input  logic [1:0]                   lk_req,
  input  logic [2:0]                   lk_pos,
  input  logic [DATA_W-1:0]            lk_rdata_in,
  output logic                         lk_hit,
  output logic                         lk_miss,
  output logic [$clog2(NUM_SLOTS)-1:0] lk_slot,
  output logic [DATA_W-1:0]            lk_rdata
);

  localparam int SLOT_W    = $clog2(NUM_SLOTS);
  localparam int NUM_BANKS = 2;

  logic [NUM_SLOTS-1:0][REG_W-1:0] bank_regs  [NUM_BANKS];
  logic                            bank_found [NUM_BANKS];
  logic [SLOT_W-1:0]               bank_idx   [NUM_BANKS];
  owner_e                          req_owner;
  logic                            sel_found;

  assign req_owner = owner_of(lk_req);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    swram_cfg_bank #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_regs (
      .clk   (clk),
      .rst   (rst),
      .we    (cfg_we && (cfg_addr[SLOT_W] == 1'(b))),
      .waddr (cfg_addr[SLOT_W-1:0]),
      .wdata (cfg_wdata),
      .slots (bank_regs[b])
    );

    swram_slot_search #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_search (
      .slots     (bank_regs[b]),
      .req_owner (req_owner),
      .req_pos   (lk_pos),
      .found     (bank_found[b]),
      .idx       (bank_idx[b])
    );
  end

  assign cfg_rdata = bank_regs[cfg_addr[SLOT_W]][cfg_addr[SLOT_W-1:0]];

  assign sel_found = bank_found[lk_bank];
  assign lk_hit    = lk_valid && sel_found;
  assign lk_miss   = lk_valid && !sel_found;
  assign lk_slot   = lk_hit ? bank_idx[lk_bank] : '0;
  assign lk_rdata  = lk_hit ? lk_rdata_in : '0;

endmodule

// File: rtl/swram_mapper_chk.sv
module swram_mapper_chk #(
  parameter int SLOT_W = 3,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_we,
  input logic [SLOT_W:0]   cfg_addr,
  input logic [7:0]        cfg_wdata,
  input logic [7:0]        cfg_rdata,
  input logic              lk_valid,
  input logic              lk_hit,
  input logic              lk_miss,
  input logic [DATA_W-1:0] lk_rdata_in,
  input logic [DATA_W-1:0] lk_rdata
);

  AST_HIT_MISS_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(lk_hit && lk_miss)); // R11

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |-> (!lk_hit && !lk_miss)); // R10

  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (rst)
    lk_miss |-> (lk_rdata == '0)); // R9

  AST_HIT_PASS: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> (lk_rdata == lk_rdata_in)); // R9

  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (rst)
    cfg_rdata[6:5] == 2'b00); // R2

  AST_WRITE_VISIBLE: assert property (@(posedge clk) disable iff (rst)
    ($past(cfg_we) && !$past(rst) && (cfg_addr == $past(cfg_addr)))
      |-> (cfg_rdata == ($past(cfg_wdata) & 8'h9F))); // R3

  AST_RESET_NO_HIT: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !lk_hit); // R1

endmodule

bind swram_slot_mapper swram_mapper_chk #(
  .SLOT_W ($clog2(NUM_SLOTS)),
  .DATA_W (DATA_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cfg_we      (cfg_we),
  .cfg_addr    (cfg_addr),
  .cfg_wdata   (cfg_wdata),
  .cfg_rdata   (cfg_rdata),
  .lk_valid    (lk_valid),
  .lk_hit      (lk_hit),
  .lk_miss     (lk_miss),
  .lk_rdata_in (lk_rdata_in),
  .lk_rdata    (lk_rdata)
);

// File: tb/swram_slot_mapper_bench.sv
`timescale 1ns/1ps
module swram_slot_mapper_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic        lk_valid = 1'b0;
  logic        lk_bank = 1'b0;
  logic [1:0]  lk_req = '0;
  logic [2:0]  lk_pos = '0;
  logic [31:0] lk_rdata_in = 32'hA5A5_0F0F;
  logic        lk_hit, lk_miss;
  logic [2:0]  lk_slot;
  logic [31:0] lk_rdata;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  swram_slot_mapper u_swram_slot_mapper (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .lk_valid(lk_valid),
    .lk_bank(lk_bank), .lk_req(lk_req), .lk_pos(lk_pos),
    .lk_rdata_in(lk_rdata_in), .lk_hit(lk_hit), .lk_miss(lk_miss),
    .lk_slot(lk_slot), .lk_rdata(lk_rdata)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_check(input logic [3:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    cfg_addr = a;
    #5;
    check(cfg_rdata == exp, tag, 32'(cfg_rdata), 32'(exp));
  endtask

  // Lookup with expected hit/slot; also checks R9 data gating and R11.
  task automatic lk_check(input logic bank, input logic [1:0] req, input logic [2:0] pos,
                          input logic valid, input bit exp_hit, input logic [2:0] exp_slot,
                          input string tag);
    logic [31:0] exp_data;
    @(negedge clk);
    lk_bank = bank; lk_req = req; lk_pos = pos; lk_valid = valid;
    #5;
    exp_data = exp_hit ? lk_rdata_in : 32'h0;
    check(lk_hit == exp_hit, {tag, " hit"}, 32'(lk_hit), 32'(exp_hit));
    check(lk_miss == (valid && !exp_hit), {tag, " miss"}, 32'(lk_miss), 32'(valid && !exp_hit));
    if (exp_hit)
      check(lk_slot == exp_slot, {tag, " slot"}, 32'(lk_slot), 32'(exp_slot));
    if (valid)
      check(lk_rdata == exp_data, {tag, " R9 data"}, lk_rdata, exp_data);
    check(!(lk_hit && lk_miss), "R11 exclusive", 32'({lk_hit, lk_miss}), 32'h0);
  endtask

  task automatic t_reset();
    for (int a = 0; a < 16; a++) rd_check(4'(a), 8'h00, "R1 reset byte");
    lk_check(1'b0, 2'd0, 3'd0, 1'b1, 0, 3'd0, "R1 lookup after reset");
    lk_check(1'b1, 2'd2, 3'd0, 1'b1, 0, 3'd0, "R1 data lookup after reset");
  endtask

  task automatic t_readback();
    wr(4'h3, 8'hFF);
    rd_check(4'h3, 8'h9F, "R2 code slot3 pad bits");
    wr(4'hD, 8'h7A);
    rd_check(4'hD, 8'h1A, "R2 data slot5 pad bits");
  endtask

  task automatic t_timing();
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 4'h0; cfg_wdata = 8'h89;
    lk_bank = 1'b0; lk_req = 2'd1; lk_pos = 3'd2; lk_valid = 1'b1;
    #5;
    check(lk_miss && !lk_hit, "R3 before edge", 32'({lk_hit, lk_miss}), 32'h1);
    check(cfg_rdata == 8'h00, "R3 readback before edge", 32'(cfg_rdata), 32'h0);
    @(posedge clk);
    #5;
    check(lk_hit && lk_slot == 3'd0, "R3 after edge", 32'({lk_hit, lk_slot}), 32'h8);
    check(cfg_rdata == 8'h89, "R3 readback after edge", 32'(cfg_rdata), 32'h89);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic t_master();
    wr(4'h1, 8'h93);
    wr(4'h2, 8'h90);
    lk_check(1'b0, 2'd2, 3'd4, 1'b1, 1, 3'd1, "R4 req2 DSP");
    lk_check(1'b0, 2'd3, 3'd4, 1'b1, 1, 3'd1, "R4 req3 DSP");
    lk_check(1'b0, 2'd1, 3'd4, 1'b1, 0, 3'd0, "R4 cpu1 no owner");
    lk_check(1'b0, 2'd0, 3'd4, 1'b1, 1, 3'd2, "R4 cpu0 owner");
    lk_check(1'b0, 2'd3, 3'd7, 1'b1, 1, 3'd3, "R4 code3 DSP");
  endtask

  task automatic t_offset();
    lk_check(1'b0, 2'd0, 3'd5, 1'b1, 0, 3'd0, "R5 wrong position");
    lk_check(1'b0, 2'd1, 3'd3, 1'b1, 0, 3'd0, "R5 cpu1 wrong position");
    lk_check(1'b0, 2'd1, 3'd2, 1'b1, 1, 3'd0, "R5 cpu1 right position");
  endtask

  task automatic t_disable();
    wr(4'h2, 8'h10);
    rd_check(4'h2, 8'h10, "R6 readback");
    lk_check(1'b0, 2'd0, 3'd4, 1'b1, 0, 3'd0, "R6 disabled slot");
    lk_check(1'b1, 2'd2, 3'd6, 1'b1, 0, 3'd0, "R6 data slot5 disabled");
  endtask

  task automatic t_bank();
    wr(4'hE, 8'h90);
    lk_check(1'b1, 2'd0, 3'd4, 1'b1, 1, 3'd6, "R7 data bank hit");
    lk_check(1'b0, 2'd0, 3'd4, 1'b1, 0, 3'd0, "R7 code bank miss");
    lk_check(1'b1, 2'd2, 3'd4, 1'b1, 0, 3'd0, "R7 code slot not in data");
  endtask

  task automatic t_priority();
    wr(4'hF, 8'h85);
    lk_check(1'b1, 2'd1, 3'd1, 1'b1, 1, 3'd7, "R8 single slot7");
    wr(4'hC, 8'h85);
    lk_check(1'b1, 2'd1, 3'd1, 1'b1, 1, 3'd4, "R8 lowest wins");
    wr(4'h8, 8'h85);
    lk_check(1'b1, 2'd1, 3'd1, 1'b1, 1, 3'd0, "R8 slot0 wins");
    wr(4'h8, 8'h05);
    wr(4'hC, 8'h05);
    lk_check(1'b1, 2'd1, 3'd1, 1'b1, 1, 3'd7, "R8 fall back to slot7");
  endtask

  task automatic t_rdata();
    lk_rdata_in = 32'hDEAD_BEEF;
    lk_check(1'b1, 2'd1, 3'd1, 1'b1, 1, 3'd7, "R9 hit passthrough");
    lk_check(1'b1, 2'd1, 3'd0, 1'b1, 0, 3'd0, "R9 miss zero");
  endtask

  task automatic t_idle();
    lk_check(1'b1, 2'd1, 3'd1, 1'b0, 0, 3'd0, "R10 idle matching");
    lk_check(1'b0, 2'd0, 3'd0, 1'b0, 0, 3'd0, "R10 idle non-matching");
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_readback();
    t_timing();
    t_master();
    t_offset();
    t_disable();
    t_bank();
    t_priority();
    t_rdata();
    t_idle();
    finish_run();
  end

  initial begin
    #(20 * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
    finish_run();
  end

endmodule